// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block holds a row of doorbells, one for each processor that can be signalled. Any bus master may ring any doorbell by writing its trigger word. Each write carries the master's identity, and the ring sets the bit of that identity rather than a bit picked from the written data. Every doorbell keeps three pieces of state: an acceptance mask owned by the receiver, a raw record of every ring, and a pending record of the rings the mask let through. A doorbell raises its level interrupt line whenever its pending record is non-zero. The receiver reads pending and writes the same value back to acknowledge it.

Several write ports can act in the same cycle. Each port is one master's path into the unit. Reads go through a separate port. That port answers one cycle after the request, and a small state machine sequences the answer. The machine has two states. RD_IDLE means no answer is due and moves to RD_RESP when a read request is seen, otherwise it stays in RD_IDLE. RD_RESP presents the captured word and stays in RD_RESP on a back-to-back request, otherwise it returns to RD_IDLE.

Doorbells sit at a power-of-two stride of 2^STRIDE_LOG2 bytes. The default stride is 0x100.

Top module: `doorbell_array`

## Requirements
- R1: After reset every acceptance mask, raw record and pending record is zero, every interrupt line is low and rd_resp is low.
- R2: A write to the trigger word (offset 0x0) with data bit 0 set sets bit m of that doorbell's raw record, where m is the writing master's identity. A trigger write with data bit 0 clear changes nothing.
- R3: A ring sets the pending bit of master m only if bit m of the acceptance mask is set in the cycle of the ring.
- R4: Each doorbell's interrupt line is high exactly while its pending record is non-zero, starting the cycle after the write that changed it.
- R5: Writing ones to the pending word (offset 0xC) clears those pending bits. Writing ones to the raw word (offset 0x8) clears those raw bits. Zero bits leave their state unchanged.
- R6: When a ring and a clear of the same bit land in the same cycle, the bit ends up set.
- R7: A write to the mask word (offset 0x4) replaces the mask. A ring in the same cycle as the write is judged by the old mask. Setting a mask bit does not move earlier raw rings into pending.
- R8: Doorbell d occupies addresses d*2^STRIDE_LOG2 + {0x0, 0x4, 0x8, 0xC}. Any other offset, and any doorbell index at or above NUM_DB, is ignored on write and reads as zero.
- R9: A read request is answered with rd_resp high exactly one cycle later. The answer is the register value from before any write made in the request cycle. The trigger word reads as zero.
- R10: A ring from a master identity at or above NUM_MASTERS is ignored.
- R11: Rings, masks and clears of one doorbell never affect another doorbell.
- R12: Rings from several ports in the same cycle all take effect. If several ports write the same mask word in the same cycle, the lowest-numbered port wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_vld | input | NUM_WPORTS | Write request, one bit per write port |
| wr_addr | input | NUM_WPORTS*ADDR_W | Byte address per port, port p at bits p*ADDR_W |
| wr_data | input | NUM_WPORTS*32 | Write data per port |
| wr_mid | input | NUM_WPORTS*MID_W | Identity of the master writing on each port |
| rd_vld | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read answer, zero-extended |
| rd_resp | output | 1 | Read answer valid |
| db_irq | output | NUM_DB | Level interrupt, one per doorbell |

## Verification
The behavioural model is stepped with the bench on every cycle.

Directed patterns each separate one pair of rules:
- A ring against a closed mask versus an open mask separates raw from pending.
- A trigger write with data bit 0 clear, and one from an out-of-range identity, show that neither writes a bit.
- An enable after a ring separates "gate at ring time" from "gate at read time".
- Ring and clear of the same bit on two ports in one cycle exposes which of them wins.
- Colliding mask writes expose the port priority.

A pseudo-random stream of mixed writes and reads, some to bad offsets, then compares the interrupt lines and every read answer against the model.

// File: rtl/dbu_pkg.sv
package dbu_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        REG_TRIG = 2'd0,
        REG_ENAB = 2'd1,
        REG_RAW  = 2'd2,
        REG_PEND = 2'd3
    } dbu_reg_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } dbu_rd_state_e;

endpackage

// File: rtl/dbu_decode.sv
module dbu_decode
    import dbu_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int STRIDE_LOG2 = 8,
    parameter int NUM_DB      = 4
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic                          hit,
    output logic [ADDR_W-STRIDE_LOG2-1:0] db_sel,
    output dbu_reg_e                      reg_sel
);

    localparam int DBI_W = ADDR_W - STRIDE_LOG2;
    // offset bits that must be zero: everything below the stride except [3:2]
    localparam logic [ADDR_W-1:0] OFS_BAD =
        ADDR_W'((64'd1 << STRIDE_LOG2) - 64'd1) & ~ADDR_W'(12);
    localparam logic [DBI_W:0] DB_LIMIT = (DBI_W+1)'(NUM_DB);

    logic [DBI_W-1:0] idx;

    assign idx     = addr[ADDR_W-1:STRIDE_LOG2];
    assign db_sel  = idx;
    assign reg_sel = dbu_reg_e'(addr[3:2]);
    assign hit     = ({1'b0, idx} < DB_LIMIT) && ((addr & OFS_BAD) == '0);

endmodule

// File: rtl/dbu_cell.sv
module dbu_cell #(
    parameter int NUM_MASTERS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] ring_vec,
    input  logic                   en_we,
    input  logic [NUM_MASTERS-1:0] en_val,
    input  logic [NUM_MASTERS-1:0] raw_clr,
    input  logic [NUM_MASTERS-1:0] pend_clr,
    output logic [NUM_MASTERS-1:0] en_q,
    output logic [NUM_MASTERS-1:0] raw_q,
    output logic [NUM_MASTERS-1:0] pend_q,
    output logic                   irq
);

    logic [NUM_MASTERS-1:0] admitted;

    // the mask in force during the ring cycle decides admission
    assign admitted = ring_vec & en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            raw_q  <= '0;
            pend_q <= '0;
        end else begin
            if (en_we) en_q <= en_val;
            // set term is applied after the clear term so a ring wins
            raw_q  <= (raw_q  & ~raw_clr)  | ring_vec;
            pend_q <= (pend_q & ~pend_clr) | admitted;
        end
    end

    assign irq = |pend_q;

    assert_ring_sets_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ring_vec) |=> ((raw_q & $past(ring_vec)) == $past(ring_vec)));

    assert_ring_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ring_vec & en_q)) |=> ((pend_q & $past(ring_vec & en_q)) == $past(ring_vec & en_q)));

    assert_only_admitted_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(ring_vec & en_q)) == '0));

    assert_irq_rises_on_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(ring_vec & en_q)));

    assert_pend_holds_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|ring_vec) && !(|pend_clr)) |=> $stable(pend_q));

endmodule

// File: rtl/dbu_read_port.sv
module dbu_read_port
    import dbu_pkg::*;
#(
    parameter int NUM_DB      = 4,
    parameter int NUM_MASTERS = 8,
    parameter int DBI_W       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_vld,
    input  logic                          rd_hit,
    input  logic [DBI_W-1:0]              rd_db,
    input  dbu_reg_e                      rd_sel,
    input  logic [NUM_DB*NUM_MASTERS-1:0] en_all,
    input  logic [NUM_DB*NUM_MASTERS-1:0] raw_all,
    input  logic [NUM_DB*NUM_MASTERS-1:0] pend_all,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rd_resp
);

    dbu_rd_state_e          state_q, state_d;
    logic [NUM_MASTERS-1:0] sel_val;
    logic [DATA_W-1:0]      word;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = rd_vld ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_vld ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        sel_val = '0;
        for (int d = 0; d < NUM_DB; d++) begin
            if (rd_db == DBI_W'(d)) begin
                case (rd_sel)
                    REG_ENAB: sel_val = en_all[d*NUM_MASTERS +: NUM_MASTERS];
                    REG_RAW:  sel_val = raw_all[d*NUM_MASTERS +: NUM_MASTERS];
                    REG_PEND: sel_val = pend_all[d*NUM_MASTERS +: NUM_MASTERS];
                    default:  sel_val = '0;
                endcase
            end
        end
        word = (rd_hit && rd_sel != REG_TRIG) ? DATA_W'(sel_val) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_vld) rd_data <= word;
    end

    always_comb begin
        unique case (state_q)
            RD_RESP: rd_resp = 1'b1;
            default: rd_resp = 1'b0;
        endcase
    end

    assert_resp_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> rd_resp);

    assert_no_resp_unasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld |=> !rd_resp);

endmodule

// File: rtl/doorbell_array.sv
module doorbell_array
    import dbu_pkg::*;
#(
    parameter int NUM_DB      = 4,
    parameter int NUM_MASTERS = 8,
    parameter int NUM_WPORTS  = 2,
    parameter int ADDR_W      = 16,
    parameter int STRIDE_LOG2 = 8,
    parameter int MID_W       = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WPORTS-1:0]        wr_vld,
    input  logic [NUM_WPORTS*ADDR_W-1:0] wr_addr,
    input  logic [NUM_WPORTS*32-1:0]     wr_data,
    input  logic [NUM_WPORTS*MID_W-1:0]  wr_mid,
    input  logic                         rd_vld,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [31:0]                  rd_data,
    output logic                         rd_resp,
    output logic [NUM_DB-1:0]            db_irq
);

    localparam int DBI_W = ADDR_W - STRIDE_LOG2;
    localparam logic [MID_W:0] NM_LIM = (MID_W+1)'(NUM_MASTERS);

    logic             w_hit [NUM_WPORTS];
    logic [DBI_W-1:0] w_db  [NUM_WPORTS];
    dbu_reg_e         w_sel [NUM_WPORTS];

    logic             r_hit;
    logic [DBI_W-1:0] r_db;
    dbu_reg_e         r_sel;

    logic [NUM_DB*NUM_MASTERS-1:0] en_all, raw_all, pend_all;

    for (genvar p = 0; p < NUM_WPORTS; p++) begin : g_wdec
        dbu_decode #(
            .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .NUM_DB(NUM_DB)
        ) u_wdec (
            .addr    (wr_addr[p*ADDR_W +: ADDR_W]),
            .hit     (w_hit[p]),
            .db_sel  (w_db[p]),
            .reg_sel (w_sel[p])
        );
    end

    dbu_decode #(
        .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .NUM_DB(NUM_DB)
    ) u_rdec (
        .addr    (rd_addr),
        .hit     (r_hit),
        .db_sel  (r_db),
        .reg_sel (r_sel)
    );

    for (genvar d = 0; d < NUM_DB; d++) begin : g_db
        logic [NUM_MASTERS-1:0] ring_v, en_v, rclr_v, pclr_v;
        logic                   en_we;

        // walk ports from highest to lowest so port 0 writes the mask last
        always_comb begin
            ring_v = '0;
            en_v   = '0;
            rclr_v = '0;
            pclr_v = '0;
            en_we  = 1'b0;
            for (int p = NUM_WPORTS-1; p >= 0; p--) begin
                if (wr_vld[p] && w_hit[p] && (w_db[p] == DBI_W'(d))) begin
                    case (w_sel[p])
                        REG_TRIG: begin
                            if (wr_data[p*32] &&
                                ({1'b0, wr_mid[p*MID_W +: MID_W]} < NM_LIM))
                                ring_v = ring_v |
                                    (NUM_MASTERS'(1) << wr_mid[p*MID_W +: MID_W]);
                        end
                        REG_ENAB: begin
                            en_we = 1'b1;
                            en_v  = wr_data[p*32 +: NUM_MASTERS];
                        end
                        REG_RAW:  rclr_v = rclr_v | wr_data[p*32 +: NUM_MASTERS];
                        default:  pclr_v = pclr_v | wr_data[p*32 +: NUM_MASTERS];
                    endcase
                end
            end
        end

        dbu_cell #(.NUM_MASTERS(NUM_MASTERS)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .ring_vec (ring_v),
            .en_we    (en_we),
            .en_val   (en_v),
            .raw_clr  (rclr_v),
            .pend_clr (pclr_v),
            .en_q     (en_all[d*NUM_MASTERS +: NUM_MASTERS]),
            .raw_q    (raw_all[d*NUM_MASTERS +: NUM_MASTERS]),
            .pend_q   (pend_all[d*NUM_MASTERS +: NUM_MASTERS]),
            .irq      (db_irq[d])
        );
    end

    dbu_read_port #(
        .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS), .DBI_W(DBI_W)
    ) u_rport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_vld   (rd_vld),
        .rd_hit   (r_hit),
        .rd_db    (r_db),
        .rd_sel   (r_sel),
        .en_all   (en_all),
        .raw_all  (raw_all),
        .pend_all (pend_all),
        .rd_data  (rd_data),
        .rd_resp  (rd_resp)
    );

    assert_irq_low_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (db_irq == '0));

endmodule

// File: tb/sim_doorbell_array.sv
module sim_doorbell_array;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  b_wr = '0;
    logic [15:0] b_addr [2];
    logic [31:0] b_data [2];
    logic [4:0]  b_mid  [2];
    logic        b_rd = 1'b0;
    logic [15:0] b_raddr = '0;
    logic [31:0] rd_data;
    logic        rd_resp;
    logic [3:0]  db_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    bit [7:0] m_en [4];
    bit [7:0] m_raw [4];
    bit [7:0] m_pend [4];

    always #2 clk = ~clk;

    doorbell_array u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_vld  (b_wr),
        .wr_addr ({b_addr[1], b_addr[0]}),
        .wr_data ({b_data[1], b_data[0]}),
        .wr_mid  ({b_mid[1], b_mid[0]}),
        .rd_vld  (b_rd),
        .rd_addr (b_raddr),
        .rd_data (rd_data),
        .rd_resp (rd_resp),
        .db_irq  (db_irq)
    );

    function automatic bit mhit(bit [15:0] a);
        return ((a >> 8) < 4) && ((a & 16'h00F3) == 0);
    endfunction

    function automatic bit [31:0] mread(bit [15:0] a);
        int idx = int'(a >> 8);
        int rs  = int'((a >> 2) & 3);
        if (!mhit(a)) return 0;
        case (rs)
            1: return {24'h0, m_en[idx]};
            2: return {24'h0, m_raw[idx]};
            3: return {24'h0, m_pend[idx]};
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(int p, bit [15:0] a, bit [31:0] d, bit [4:0] m);
        b_wr[p] = 1'b1; b_addr[p] = a; b_data[p] = d; b_mid[p] = m;
    endtask

    task automatic rdq(bit [15:0] a);
        b_rd = 1'b1; b_raddr = a;
    endtask

    // one clock: model advances, outputs compared at the following falling edge
    task automatic step(string tag);
        bit [31:0] exp_rd;
        bit        exp_resp;
        bit [3:0]  exp_irq;
        exp_resp = b_rd;
        exp_rd   = mread(b_raddr);
        for (int d = 0; d < 4; d++) begin
            bit [7:0] rv = 0, rc = 0, pc = 0, ev = m_en[d];
            bit ew = 0;
            for (int p = 1; p >= 0; p--) begin
                if (b_wr[p] && mhit(b_addr[p]) && int'(b_addr[p] >> 8) == d) begin
                    case ((b_addr[p] >> 2) & 3)
                        0: if (b_data[p][0] && b_mid[p] < 8) rv[b_mid[p][2:0]] = 1'b1;
                        1: begin ew = 1; ev = b_data[p][7:0]; end
                        2: rc = rc | b_data[p][7:0];
                        default: pc = pc | b_data[p][7:0];
                    endcase
                end
            end
            m_pend[d] = (m_pend[d] & ~pc) | (rv & m_en[d]);
            m_raw[d]  = (m_raw[d] & ~rc) | rv;
            if (ew) m_en[d] = ev;
        end
        @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 4; d++) exp_irq[d] = (m_pend[d] != 0);
        chk(tag, "irq", {28'h0, db_irq}, {28'h0, exp_irq});
        chk(tag, "rd_resp", {31'h0, rd_resp}, {31'h0, exp_resp});
        if (exp_resp) chk(tag, "rd_data", rd_data, exp_rd);
        b_wr = '0;
        b_rd = 1'b0;
    endtask

    task automatic rcheck(bit [15:0] a, string tag);
        rdq(a);
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit [31:0] lf = 32'h1D2C3B4A;
        for (int p = 0; p < 2; p++) begin b_addr[p] = '0; b_data[p] = '0; b_mid[p] = '0; end
        for (int d = 0; d < 4; d++) begin m_en[d] = 0; m_raw[d] = 0; m_pend[d] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1");
        // R1: reset contents
        rcheck(16'h0004, "R1"); rcheck(16'h0008, "R1"); rcheck(16'h000C, "R1");
        rcheck(16'h0304, "R1"); rcheck(16'h030C, "R1");
        // R2/R3: ring db1 from master 2 with a closed mask
        wr(0, 16'h0100, 32'h1, 5'd2); step("R2");
        rcheck(16'h0108, "R2"); rcheck(16'h010C, "R3");
        // R2: data bit 0 clear does not ring
        wr(0, 16'h0100, 32'hFFFF_FFFE, 5'd5); step("R2");
        rcheck(16'h0108, "R2");
        // R7: opening the mask does not pull in old rings
        wr(0, 16'h0104, 32'h0C, 5'd0); step("R7");
        rcheck(16'h010C, "R7");
        // R3/R4: admitted ring raises irq
        wr(1, 16'h0100, 32'h1, 5'd3); step("R3");
        rcheck(16'h010C, "R4");
        // R10: identity out of range
        wr(0, 16'h0100, 32'h1, 5'd9); step("R10");
        rcheck(16'h0108, "R10");
        // R8: bad offset and out-of-range doorbell
        wr(0, 16'h0110, 32'h1, 5'd1); step("R8");
        wr(1, 16'h0400, 32'h1, 5'd1); step("R8");
        rcheck(16'h0108, "R8"); rcheck(16'h0404, "R8"); rcheck(16'h0102, "R8");
        // R9: trigger reads zero
        rcheck(16'h0100, "R9");
        // R11: another doorbell
        wr(0, 16'h0200, 32'h1, 5'd1); step("R11");
        rcheck(16'h0208, "R11"); rcheck(16'h0108, "R11"); rcheck(16'h010C, "R11");
        // R6: ring and clear of the same pending bit in one cycle
        wr(0, 16'h010C, 32'h08, 5'd0); wr(1, 16'h0100, 32'h1, 5'd3); step("R6");
        rcheck(16'h010C, "R6");
        // R5: clears
        wr(0, 16'h010C, 32'h08, 5'd0); step("R5");
        rcheck(16'h010C, "R5");
        wr(1, 16'h0108, 32'h04, 5'd0); step("R5");
        rcheck(16'h0108, "R5");
        // R12: two rings at once
        wr(0, 16'h0100, 32'h1, 5'd2); wr(1, 16'h0100, 32'h1, 5'd3); step("R12");
        rcheck(16'h010C, "R12");
        // R12: mask collision, port 0 wins
        wr(0, 16'h0304, 32'h01, 5'd0); wr(1, 16'h0304, 32'hFF, 5'd0); step("R12");
        rcheck(16'h0304, "R12");
        // R7: ring in the same cycle as a mask write uses the old mask
        wr(0, 16'h0304, 32'h80, 5'd0); wr(1, 16'h0300, 32'h1, 5'd7); step("R7");
        rcheck(16'h030C, "R7");
        // R9: read in the ring cycle returns the old value
        wr(0, 16'h0300, 32'h1, 5'd7); rdq(16'h030C); step("R9");
        rcheck(16'h030C, "R9");
        // mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            for (int p = 0; p < 2; p++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                if (lf[0]) begin
                    bit [15:0] a = {5'h0, lf[11:9], 8'h00} | (lf[12] ? 16'h0010 : 16'h0000)
                                   | {12'h0, lf[14:13], 2'b00};
                    wr(p, a, {24'h0, lf[23:16]}, lf[28:24] % 5'd12);
                end
            end
            if (lf[5]) rdq({6'h0, lf[7:6], 6'h0, lf[3:2], 2'b00});
            step("R4");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule